// File: doc/BRIEF.md
# Time-Slot Windowed Pattern Checker

This block watches a byte stream that is cut into frames of numbered time slots and checks a known test pattern carried in a chosen band of those slots. Software gives it an inclusive slot range, a pattern style, a user byte for the fixed-byte style, a frame-rate selector and a start bit. While started, the checker compares every tested byte against the byte it expects. After a run of consecutive matches it declares lock. Once locked, it reports each mismatching byte with a one-cycle error pulse.

The pattern can be a constant byte (user-set, all zeros or all ones) or a 15-stage pseudo-random sequence. For the pseudo-random style the checker loads its shift register from the received bytes before lock, so it needs no seed. After lock the register free-runs, so one corrupted byte yields exactly one error. A sticky detect flag reports lock. Reading the flag clears it, and it can be raised only once for each low-then-high transition of the start bit.

A frame boundary strobe marks each new frame. The rate selector lets the checker test only every second, fourth or eighth frame.

Top module: `slot_pattern_checker`

## Requirements
- R1: A byte is tested only when `byte_vld` is high and `win_lo <= slot_idx <= win_hi`. `win_lo == win_hi` tests one slot, and `win_lo > win_hi` tests none. Bytes in other slots never cause an error and never count toward lock.
- R2: `style` 0 expects `user_byte`, 2 expects 8'h00, 3 expects 8'hFF, and 1 selects the pseudo-random sequence. Every other code never locks and never reports an error.
- R3: The pseudo-random sequence uses x^15+x^14+1. Each new bit is stage 15 XOR stage 14, and the bits are carried MSB first within a byte. The first two tested bytes after arming fill the register and are not compared. Comparison starts with the third tested byte.
- R4: `frame_start` pulses count frames from zero, starting when `start` rises. With N = 2^`rate`, a byte is tested only while that frame count is a multiple of N. The count is cleared while `start` is 0.
- R5: Lock is declared on the eighth consecutive matching tested byte. A tested mismatch before lock restarts the run from zero.
- R6: `detect_flag` rises on the clock edge that takes in the locking byte, and it stays high until read.
- R7: A one-cycle `detect_rd` pulse clears `detect_flag` on the following edge.
- R8: `detect_flag` can be raised at most once per arming. Arming is a 0-to-1 transition of `start`, and the checker stays locked after the flag is read.
- R9: After lock, a tested byte that differs from the expected byte produces a one-cycle `err_pulse` on the next edge. Matching bytes produce none.
- R10: While `start` is 0, the checker is held unlocked and `err_pulse` stays low.
- R11: After pseudo-random lock, the expected sequence runs on by itself, so one corrupted byte followed by correct bytes gives exactly one error.
- R12: After reset, `detect_flag` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at each frame boundary |
| byte_vld | input | 1 | A byte for `slot_idx` is present |
| slot_idx | input | SLOT_W | Slot number of the present byte |
| byte_in | input | 8 | Received byte |
| win_lo | input | SLOT_W | Lowest tested slot |
| win_hi | input | SLOT_W | Highest tested slot |
| style | input | 4 | Pattern selector |
| user_byte | input | 8 | Byte expected by style 0 |
| rate | input | 2 | Tests one frame in 2^rate |
| start | input | 1 | Arms the checker while high |
| detect_rd | input | 1 | Read strobe that clears the detect flag |
| detect_flag | output | 1 | Sticky lock indication |
| err_pulse | output | 1 | One-cycle mismatch indication after lock |

## Verification
The assertions check on every cycle that an error pulse always follows an in-window valid byte and never follows a stopped cycle. They also check that the detect flag rises only while armed and falls only after a read, and that the match run, the fill count and the frame count stay within their bounds. Only the scenarios can show the exact byte on which lock occurs for each style and rate, the slots selected by each window pair, and the single error from a corrupted pseudo-random byte. The same holds for the run restart after a pre-lock mismatch and for the flag staying clear after a read until the checker is re-armed.

// File: rtl/spc_pkg.sv
// Shared constants and the pseudo-random byte predictor for the slot pattern checker.
// Assumes bytes are carried MSB first and the sequence is x^15+x^14+1.
package spc_pkg;
    localparam int PRBS_W = 15;
    localparam int RATE_W = 2;

    localparam logic [3:0] STY_USER = 4'h0;
    localparam logic [3:0] STY_PRBS = 4'h1;
    localparam logic [3:0] STY_ZERO = 4'h2;
    localparam logic [3:0] STY_ONES = 4'h3;

    // Next eight sequence bits from a register state, first bit in the MSB.
    function automatic logic [7:0] prbs_next_byte(input logic [PRBS_W-1:0] s);
        logic [PRBS_W-1:0] t;
        logic [7:0]        b;
        logic              nb;
        t = s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            nb = t[PRBS_W-1] ^ t[PRBS_W-2];
            t  = {t[PRBS_W-2:0], nb};
            b  = {b[6:0], nb};
        end
        return b;
    endfunction
endpackage

// File: rtl/spc_slot_gate.sv
// Decides which incoming bytes are tested: in-window slots of selected frames.
// Assumes frame_start and byte_vld come from the same framing logic;
// the frame count restarts from zero whenever start is low.
module spc_slot_gate
    import spc_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frame_start,
    input  logic              byte_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [SLOT_W-1:0] win_lo,
    input  logic [SLOT_W-1:0] win_hi,
    input  logic [RATE_W-1:0] rate,
    output logic              test_stb
);
    localparam int FCNT_W = (1 << RATE_W) - 1;

    logic [FCNT_W-1:0] fcnt_q;
    logic [FCNT_W-1:0] ones;
    logic [FCNT_W-1:0] mask;
    logic              in_win;
    logic              frame_sel;

    // Frame counter since arming, wrapping at the largest rate divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            fcnt_q <= '0;
        end else if (frame_start) begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    // Window compare and frame-rate selection.
    always_comb begin
        ones      = '1;
        mask      = ~(ones << rate);
        in_win    = (slot_idx >= win_lo) && (slot_idx <= win_hi);
        frame_sel = ((fcnt_q & mask) == '0);
        test_stb  = start && byte_vld && in_win && frame_sel;
    end

    // R4: the frame count restarts while the checker is stopped.
    a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!start) |-> (fcnt_q == '0));
endmodule

// File: rtl/spc_expect_gen.sv
// Produces the expected byte for the selected style and says when it is valid.
// The pseudo-random register loads from received bytes until lock, then free-runs.
// Assumes step is high only for tested bytes.
module spc_expect_gen
    import spc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       step,
    input  logic       locked,
    input  logic [3:0] style,
    input  logic [7:0] user_byte,
    input  logic [7:0] rx_byte,
    output logic [7:0] exp_byte,
    output logic       exp_valid
);
    localparam logic [1:0] FILL_DONE = 2'd2;

    logic [PRBS_W-1:0] state_q;
    logic [1:0]        fill_q;
    logic [7:0]        pred;

    // Predicted byte and expected value per style.
    always_comb begin
        pred = prbs_next_byte(state_q);
        case (style)
            STY_USER: begin exp_byte = user_byte; exp_valid = 1'b1; end
            STY_ZERO: begin exp_byte = 8'h00;     exp_valid = 1'b1; end
            STY_ONES: begin exp_byte = 8'hFF;     exp_valid = 1'b1; end
            STY_PRBS: begin exp_byte = pred;      exp_valid = (fill_q == FILL_DONE); end
            default:  begin exp_byte = 8'h00;     exp_valid = 1'b0; end
        endcase
    end

    // Shift register update: self-load before lock, free-run after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            fill_q  <= '0;
        end else if (!start) begin
            fill_q  <= '0;
        end else if (step && style == STY_PRBS) begin
            state_q <= {state_q[PRBS_W-9:0], (locked ? pred : rx_byte)};
            if (fill_q != FILL_DONE) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R3: the fill count never passes two bytes.
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_DONE);
endmodule

// File: rtl/spc_lock_ctrl.sv
// Counts consecutive matches to lock, raises the sticky detect flag once per
// arming, and emits error pulses on mismatches after lock.
// Assumes test_stb is already gated by start and by the window.
module spc_lock_ctrl #(
    parameter int LOCK_RUN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       test_stb,
    input  logic       exp_valid,
    input  logic [7:0] exp_byte,
    input  logic [7:0] rx_byte,
    input  logic       detect_rd,
    output logic       locked,
    output logic       detect_flag,
    output logic       err_pulse
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    logic [RUN_W-1:0] run_q;
    logic             locked_q;
    logic             err_q;
    logic             armed_q;
    logic             start_q;
    logic             detect_q;
    logic             hit;
    logic             same;
    logic             lock_evt;

    // Compare the tested byte and find the locking byte.
    always_comb begin
        hit      = test_stb && exp_valid;
        same     = (rx_byte == exp_byte);
        lock_evt = !locked_q && hit && same && (run_q == RUN_W'(LOCK_RUN - 1));
    end

    // Match run, lock state and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            run_q    <= '0;
            locked_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= locked_q && hit && !same;
            if (lock_evt) begin
                locked_q <= 1'b1;
                run_q    <= '0;
            end else if (!locked_q && hit) begin
                run_q <= same ? run_q + 1'b1 : '0;
            end
        end
    end

    // Arming on start rising, and the sticky detect flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            armed_q  <= 1'b0;
            detect_q <= 1'b0;
        end else begin
            start_q <= start;
            if (!start) begin
                armed_q <= 1'b0;
            end else if (!start_q) begin
                armed_q <= 1'b1;
            end else if (lock_evt) begin
                armed_q <= 1'b0;
            end
            if (lock_evt && armed_q) begin
                detect_q <= 1'b1;
            end else if (detect_rd) begin
                detect_q <= 1'b0;
            end
        end
    end

    assign locked      = locked_q;
    assign detect_flag = detect_q;
    assign err_pulse   = err_q;

    // R5: the match run stays below the lock length.
    a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(LOCK_RUN));
    // R8: the flag rises only from an armed state, which is then spent.
    a_r8_detect_once: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect_q) |-> ($past(armed_q) && !armed_q));
    // R6: the flag drops only after a read.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detect_q) |-> $past(detect_rd));
    // R9: errors are reported only while locked.
    a_r9_err_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> locked_q);
endmodule

// File: rtl/slot_pattern_checker.sv
// Top of the windowed time-slot pattern checker: slot gate, expected-byte
// generator and lock controller. Assumes one byte per cycle at most and
// configuration held steady while bytes are tested.
module slot_pattern_checker
    import spc_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int LOCK_RUN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              byte_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [7:0]        byte_in,
    input  logic [SLOT_W-1:0] win_lo,
    input  logic [SLOT_W-1:0] win_hi,
    input  logic [3:0]        style,
    input  logic [7:0]        user_byte,
    input  logic [RATE_W-1:0] rate,
    input  logic              start,
    input  logic              detect_rd,
    output logic              detect_flag,
    output logic              err_pulse
);
    logic       test_stb;
    logic       locked;
    logic [7:0] exp_byte;
    logic       exp_valid;

    spc_slot_gate #(.SLOT_W(SLOT_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .frame_start (frame_start),
        .byte_vld    (byte_vld),
        .slot_idx    (slot_idx),
        .win_lo      (win_lo),
        .win_hi      (win_hi),
        .rate        (rate),
        .test_stb    (test_stb)
    );

    spc_expect_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step      (test_stb),
        .locked    (locked),
        .style     (style),
        .user_byte (user_byte),
        .rx_byte   (byte_in),
        .exp_byte  (exp_byte),
        .exp_valid (exp_valid)
    );

    spc_lock_ctrl #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .test_stb    (test_stb),
        .exp_valid   (exp_valid),
        .exp_byte    (exp_byte),
        .rx_byte     (byte_in),
        .detect_rd   (detect_rd),
        .locked      (locked),
        .detect_flag (detect_flag),
        .err_pulse   (err_pulse)
    );

    // R1: an error always follows a valid byte inside the window.
    a_r1_err_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(byte_vld && slot_idx >= win_lo && slot_idx <= win_hi));
    // R10: no error follows a cycle with the checker stopped.
    a_r10_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!start) |-> !err_pulse);
endmodule

// File: tb/slot_pattern_checker_test.sv
module slot_pattern_checker_test;
    localparam int SLOT_W = 5;
    localparam int NSLOT  = 1 << SLOT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              byte_vld = 1'b0;
    logic [SLOT_W-1:0] slot_idx = '0;
    logic [7:0]        byte_in = '0;
    logic [SLOT_W-1:0] win_lo = '0;
    logic [SLOT_W-1:0] win_hi = '0;
    logic [3:0]        style = '0;
    logic [7:0]        user_byte = '0;
    logic [1:0]        rate = '0;
    logic              start = 1'b0;
    logic              detect_rd = 1'b0;
    logic              detect_flag;
    logic              err_pulse;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  fd [NSLOT];
    logic [31:0] err_mask;
    logic [31:0] det_mask;
    logic [14:0] pstate;

    slot_pattern_checker #(.SLOT_W(SLOT_W), .LOCK_RUN(8)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_vld(byte_vld),
        .slot_idx(slot_idx), .byte_in(byte_in), .win_lo(win_lo), .win_hi(win_hi),
        .style(style), .user_byte(user_byte), .rate(rate), .start(start),
        .detect_rd(detect_rd), .detect_flag(detect_flag), .err_pulse(err_pulse)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic prbs_byte(output logic [7:0] b);
        logic nb;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            nb     = pstate[14] ^ pstate[13];
            pstate = {pstate[13:0], nb};
            b      = {b[6:0], nb};
        end
    endtask

    task automatic arm(input logic [3:0] sty, input logic [7:0] ub, input logic [1:0] rt,
                       input int lo, input int hi);
        @(negedge clk);
        start = 1'b0;
        style = sty; user_byte = ub; rate = rt;
        win_lo = SLOT_W'(lo); win_hi = SLOT_W'(hi);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_det();
        @(negedge clk);
        detect_rd = 1'b1;
        @(negedge clk);
        detect_rd = 1'b0;
    endtask

    task automatic send_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        err_mask = '0;
        det_mask = '0;
        for (int s = 0; s < NSLOT; s++) begin
            slot_idx = SLOT_W'(s);
            byte_in  = fd[s];
            byte_vld = 1'b1;
            @(negedge clk);
            byte_vld    = 1'b0;
            err_mask[s] = err_pulse;
            det_mask[s] = detect_flag;
        end
    endtask

    task automatic fill_all(input logic [7:0] v);
        for (int s = 0; s < NSLOT; s++) fd[s] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pb;
        logic [31:0] em;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 detect after reset", 32'(detect_flag), 0);
        chk("R12 err after reset", 32'(err_pulse), 0);

        // User byte, window 4..6: lock on 8th tested byte (frame 3, slot 5)
        arm(4'h0, 8'hA5, 2'd0, 4, 6);
        for (int s = 0; s < NSLOT; s++) fd[s] = (s >= 4 && s <= 6) ? 8'hA5 : 8'(s) ^ 8'h3C;
        send_frame();
        chk("R1 R5 frame1 err", err_mask, 0);
        chk("R5 frame1 no lock", det_mask, 0);
        send_frame();
        chk("R5 frame2 no lock", det_mask, 0);
        send_frame();
        chk("R6 lock on eighth byte", det_mask, 32'hFFFFFFE0);
        chk("R1 no error off-window", err_mask, 0);
        fd[5] = 8'h5A; fd[10] = 8'hA5 ^ 8'hFF;
        send_frame();
        chk("R9 R1 single in-window error", err_mask, 32'h00000020);
        chk("R6 flag sticky", det_mask, 32'hFFFFFFFF);
        read_det();
        chk("R7 read clears", 32'(detect_flag), 0);
        fd[5] = 8'hA5;
        send_frame();
        chk("R8 no second detect", det_mask, 0);
        chk("R8 still locked clean", err_mask, 0);
        @(negedge clk); start = 1'b0;
        fd[4] = 8'h00; fd[5] = 8'h00; fd[6] = 8'h00;
        send_frame();
        chk("R10 no error when stopped", err_mask, 0);
        // Re-arm, mismatch before lock restarts the run
        arm(4'h0, 8'hA5, 2'd0, 4, 6);
        fd[4] = 8'hA5; fd[5] = 8'hA5; fd[6] = 8'hA5;
        send_frame(); send_frame();
        fd[4] = 8'h00;
        send_frame();
        chk("R5 mismatch before lock no error", err_mask, 0);
        fd[4] = 8'hA5;
        send_frame();
        chk("R5 run restarted", det_mask, 0);
        send_frame();
        chk("R5 R8 relock after rearm", det_mask, 32'hFFFFFFC0);
        read_det();

        // Pseudo-random, single slot 9
        arm(4'h1, 8'h00, 2'd0, 9, 9);
        pstate = 15'h4D2B;
        fill_all(8'h00);
        for (int f = 1; f <= 10; f++) begin
            prbs_byte(pb);
            fd[9] = pb;
            send_frame();
            if (f == 9) chk("R3 no lock before tenth byte", det_mask, 0);
            if (f == 10) chk("R3 R1 prbs lock on tenth byte", det_mask, 32'hFFFFFE00);
            if (f >= 9) chk("R3 no error during fill and lock", err_mask, 0);
        end
        prbs_byte(pb);
        fd[9] = pb ^ 8'h10;
        send_frame();
        chk("R11 corrupted byte flagged", err_mask, 32'h00000200);
        prbs_byte(pb);
        fd[9] = pb;
        send_frame();
        chk("R11 free-run no extra error", err_mask, 0);
        read_det();

        // Rate sweep: single slot 0, lock after 8 tested frames
        for (int r = 0; r < 4; r++) begin
            n = 1 << r;
            arm(4'h0, 8'h3C, 2'(r), 0, 0);
            fill_all(8'hC3);
            fd[0] = 8'h3C;
            for (int k = 1; k <= 8 * n; k++) begin
                send_frame();
                if (k == 8 * n - 1) chk("R4 rate no lock yet", 32'(detect_flag), 0);
            end
            chk("R4 rate lock frame", 32'(detect_flag), 1);
            fd[0] = 8'h00;
            em = 0;
            for (int k = 1; k <= 2 * n; k++) begin
                send_frame();
                em += 32'($countones(err_mask));
            end
            chk("R4 rate tested error frames", em, 2);
            read_det();
        end

        // Window sweep with all-zero style locked on full window
        arm(4'h2, 8'h00, 2'd0, 0, 31);
        fill_all(8'h00);
        send_frame();
        chk("R2 zero style lock", det_mask, 32'hFFFFFF80);
        fill_all(8'hFF);
        for (int lo = 0; lo < NSLOT; lo += 3) begin
            for (int hi = 0; hi < NSLOT; hi += 4) begin
                @(negedge clk);
                win_lo = SLOT_W'(lo); win_hi = SLOT_W'(hi);
                em = 0;
                for (int s = 0; s < NSLOT; s++) if (s >= lo && s <= hi) em[s] = 1'b1;
                send_frame();
                chk("R1 window sweep", err_mask, em);
            end
        end
        read_det();

        // Unsupported style never locks; all-ones style locks
        arm(4'h9, 8'h00, 2'd0, 0, 31);
        fill_all(8'h00);
        for (int f = 0; f < 3; f++) begin
            send_frame();
            chk("R2 unsupported no lock", det_mask, 0);
            chk("R2 unsupported no error", err_mask, 0);
        end
        arm(4'h3, 8'h00, 2'd0, 0, 31);
        fill_all(8'hFF);
        send_frame();
        chk("R2 ones style lock", det_mask, 32'hFFFFFF80);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule